// File: doc/BRIEF.md
# Leading-One Residual Angle Recoder

This block turns the signed residual angle of an iterative vector-rotation engine into the next pair of elementary rotation steps. It finds the first bit below the sign bit that differs from the sign. For a non-negative residual this is the leading one. For a negative residual it is the leading zero. The distance of that bit from the top of the fraction is the position k. The block then reads a 4-bit window of the magnitude starting at that bit. A recoding table maps the window to two shift indices, m and n. Their elementary angles atan(2^-m) + atan(2^-n) together give the closest match to the residual. This skips the iterations that a plain one-step-per-bit scheme would spend on leading bits that carry no information.

The recoding table has two variants. Positions 0 and 1 use their own variant, because the first arctangent steps are far from 2^-k. A zero residual raises a done flag instead of a pair. The output can be registered (parameter `REG_OUT`, default 1, one cycle of latency) or taken straight from the combinational logic.

The residual is `W` bits wide (default 12) in two's complement. Bit `W-1` is the sign. Position k counts down from bit `W-2` (k = 0) to bit 0 (k = W-2).

Top module: `cordic_recoder`

## Requirements
- R1: A residual of all zeros drives `zero_o`=1, `k_idx`=`m_idx`=`n_idx`=0, `err_o`=0 and `dir_neg`=0.
- R2: For any non-zero residual, `zero_o`=0 and `dir_neg` equals residual bit W-1. This one sign gives the direction of both elementary angles.
- R3: For a non-zero, non-negative residual, `k_idx` is the number of zero bits between the sign bit and the highest one bit. For a negative residual, `k_idx` is the number of one bits between the sign bit and the highest zero bit.
- R4: The window is the highest magnitude bit and the three bits below it, most significant first. The magnitude is the residual bits W-2..0, inverted when the residual is negative. Window bits that would fall below bit 0 read as zero.
- R5: For k > 1, the window maps to (m, n) as follows: 1000→(k,k+4), 1001→(k,k+3), 1010→(k,k+2), 1011/1100/1101→(k,k+1), 1110→(k-1,k+5), 1111→(k-1,k+3).
- R6: For k ≤ 1, the window maps to (m, n) as follows: 1000→(k,k+3), 1001 and 1010→(k,k+2), 1011 and 1100→(k,k+1). In all these cases `err_o`=0.
- R7: For k ≤ 1 with window 1101, 1110 or 1111, `err_o`=1 and the pair is (k, k+1). `err_o` is 0 whenever k > 1.
- R8: A residual of all ones (the smallest negative value) is treated as one LSB of magnitude. It gives k = W-2 and window 1000, so the pair is (W-2, W+2).
- R9: With `REG_OUT`=1, the outputs show the result for the residual sampled at the previous rising clock edge. An active-low `rst_n` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| resid | input | W | Signed residual angle |
| k_idx | output | $clog2(W+4) | Leading-bit position k |
| m_idx | output | $clog2(W+4) | First shift index |
| n_idx | output | $clog2(W+4) | Second shift index |
| dir_neg | output | 1 | Rotation direction (1 = negative) |
| zero_o | output | 1 | Residual is zero, rotation complete |
| err_o | output | 1 | Window not expected at position 0 or 1 |

## Verification
The block holds no state beyond the optional output register. A fault in the detector or the table therefore shows at the ports one cycle after the residual that exposes it, and it does not persist into later cycles. A wrong position shifts k, m and n together, so n - k leaves the range 1..5 or m drops below k - 1. A wrong table entry alters only m or n, and only for the window and position group that selects it. For that reason every window value is driven at a low position and at a high position. An error in magnitude inversion shows only for negative residuals, and most plainly for the all-ones and sign-only patterns.

// File: rtl/cordic_recoder_pkg.sv
package cordic_recoder_pkg;

    // Recoded step: m = k - m_dec, n = k + n_off
    typedef struct packed {
        logic       m_dec;
        logic [2:0] n_off;
        logic       err;
    } rec_code_t;

    // Table used once the leading bit is deeper than position 1
    function automatic rec_code_t code_far(input logic [3:0] win);
        rec_code_t c;
        c = '{m_dec: 1'b0, n_off: 3'd1, err: 1'b0};
        unique case (win)
            4'b1000: c.n_off = 3'd4;
            4'b1001: c.n_off = 3'd3;
            4'b1010: c.n_off = 3'd2;
            4'b1110: begin c.m_dec = 1'b1; c.n_off = 3'd5; end
            4'b1111: begin c.m_dec = 1'b1; c.n_off = 3'd3; end
            default: c.n_off = 3'd1;
        endcase
        return c;
    endfunction

    // Table for positions 0 and 1 (coarse steps)
    function automatic rec_code_t code_near(input logic [3:0] win);
        rec_code_t c;
        c = '{m_dec: 1'b0, n_off: 3'd1, err: 1'b0};
        unique case (win)
            4'b1000: c.n_off = 3'd3;
            4'b1001,
            4'b1010: c.n_off = 3'd2;
            4'b1011,
            4'b1100: c.n_off = 3'd1;
            default: c.err   = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cr_lead_detect.sv
module cr_lead_detect #(
    parameter int W  = 12,
    parameter int IW = $clog2(W + 4)
) (
    input  logic [W-1:0]  resid,
    output logic [IW-1:0] k,
    output logic [3:0]    win,
    output logic          is_zero,
    output logic          sgn
);
    localparam int FW = W - 1;

    logic [FW-1:0]   mag;
    logic [FW+2:0]   ext;
    logic [IW-1:0]   pos;
    logic            found;

    always_comb begin
        sgn     = resid[W-1];
        is_zero = (resid == '0);
        mag     = sgn ? ~resid[FW-1:0] : resid[FW-1:0];
        found   = 1'b0;
        pos     = '0;
        for (int i = 0; i < FW; i++) begin
            if (mag[i]) begin
                pos   = IW'(i);
                found = 1'b1;
            end
        end
        ext = {mag, 3'b000} >> pos;
        if (found) begin
            win = ext[3:0];
        end else begin
            // all-ones residual: one LSB of magnitude
            win = 4'b1000;
        end
        k = IW'(FW - 1) - pos;
    end

endmodule

// File: rtl/cr_rec_table.sv
module cr_rec_table
    import cordic_recoder_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [IW-1:0] k,
    input  logic [3:0]    win,
    output logic [IW-1:0] m,
    output logic [IW-1:0] n,
    output logic          err
);
    rec_code_t code;

    always_comb begin
        if (k <= IW'(1)) begin
            code = code_near(win);
        end else begin
            code = code_far(win);
        end
        m   = k - IW'(code.m_dec);
        n   = k + IW'(code.n_off);
        err = code.err;
    end

endmodule

// File: rtl/cordic_recoder.sv
module cordic_recoder #(
    parameter int W       = 12,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [W-1:0]             resid,
    output logic [$clog2(W+4)-1:0]   k_idx,
    output logic [$clog2(W+4)-1:0]   m_idx,
    output logic [$clog2(W+4)-1:0]   n_idx,
    output logic                     dir_neg,
    output logic                     zero_o,
    output logic                     err_o
);
    localparam int IW = $clog2(W + 4);

    logic [IW-1:0] k_c, m_c, n_c;
    logic [IW-1:0] k_t, m_t, n_t;
    logic [3:0]    win_c;
    logic          zero_c, sgn_c, err_t;
    logic          dir_t, err_c;

    cr_lead_detect #(.W(W), .IW(IW)) u_detect (
        .resid   (resid),
        .k       (k_t),
        .win     (win_c),
        .is_zero (zero_c),
        .sgn     (sgn_c)
    );

    cr_rec_table #(.IW(IW)) u_table (
        .k   (k_t),
        .win (win_c),
        .m   (m_t),
        .n   (n_t),
        .err (err_t)
    );

    // a zero residual overrides the recoded pair
    always_comb begin
        if (zero_c) begin
            k_c   = '0;
            m_c   = '0;
            n_c   = '0;
            err_c = 1'b0;
            dir_t = 1'b0;
        end else begin
            k_c   = k_t;
            m_c   = m_t;
            n_c   = n_t;
            err_c = err_t;
            dir_t = sgn_c;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    k_idx   <= '0;
                    m_idx   <= '0;
                    n_idx   <= '0;
                    dir_neg <= 1'b0;
                    zero_o  <= 1'b0;
                    err_o   <= 1'b0;
                end else begin
                    k_idx   <= k_c;
                    m_idx   <= m_c;
                    n_idx   <= n_c;
                    dir_neg <= dir_t;
                    zero_o  <= zero_c;
                    err_o   <= err_c;
                end
            end
        end else begin : g_comb
            always_comb begin
                k_idx   = k_c;
                m_idx   = m_c;
                n_idx   = n_c;
                dir_neg = dir_t;
                zero_o  = zero_c;
                err_o   = err_c;
            end
        end
    endgenerate

endmodule

// File: rtl/cordic_recoder_chk.sv
module cordic_recoder_chk #(
    parameter int W       = 12,
    parameter bit REG_OUT = 1'b1,
    parameter int IW      = $clog2(W + 4)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  resid,
    input logic [IW-1:0] k_idx,
    input logic [IW-1:0] m_idx,
    input logic [IW-1:0] n_idx,
    input logic          dir_neg,
    input logic          zero_o,
    input logic          err_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (k_idx == '0 && m_idx == '0 && n_idx == '0 && !err_o && !dir_neg)); // R1

    AST_ERR_LOW_POS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (k_idx <= IW'(1) && n_idx == k_idx + IW'(1) && m_idx == k_idx)); // R7

    AST_N_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_o && armed |-> (n_idx > k_idx && n_idx <= k_idx + IW'(5))); // R5

    AST_M_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_o && m_idx != k_idx) |-> (k_idx > IW'(1) && m_idx == k_idx - IW'(1))); // R6

    AST_K_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        k_idx <= IW'(W - 2)); // R3

    generate
        if (REG_OUT) begin : g_seq
            AST_DIR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
                armed |-> (zero_o == ($past(resid) == '0) &&
                           (zero_o || dir_neg == $past(resid[W-1])))); // R2
        end
    endgenerate

endmodule

bind cordic_recoder cordic_recoder_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/cordic_recoder_test.sv
module cordic_recoder_test;
    localparam int W  = 12;
    localparam int IW = $clog2(W + 4);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  resid = '0;
    logic [IW-1:0] k_idx, m_idx, n_idx;
    logic          dir_neg, zero_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cordic_recoder #(.W(W), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .resid(resid),
        .k_idx(k_idx), .m_idx(m_idx), .n_idx(n_idx),
        .dir_neg(dir_neg), .zero_o(zero_o), .err_o(err_o)
    );

    // reference model written from the requirements
    task automatic model(input logic [W-1:0] r, output int ek, output int em,
                         output int en, output bit ed, output bit ez, output bit ee);
        logic [W-2:0] mg;
        int hi;
        logic [3:0] w;
        ek = 0; em = 0; en = 0; ed = 0; ez = 0; ee = 0;
        if (r == '0) begin
            ez = 1;                                   // R1
            return;
        end
        ed = r[W-1];                                  // R2
        mg = r[W-1] ? ~r[W-2:0] : r[W-2:0];
        hi = -1;
        for (int b = W - 2; b >= 0; b--)
            if (hi < 0 && mg[b]) hi = b;
        if (hi < 0) begin                             // R8
            ek = W - 2; w = 4'b1000;
        end else begin
            ek = (W - 2) - hi;                        // R3
            for (int j = 0; j < 4; j++)               // R4
                w[3-j] = (hi - j >= 0) ? mg[hi-j] : 1'b0;
        end
        em = ek;
        if (ek > 1) begin                             // R5
            case (w)
                4'b1000: en = ek + 4;
                4'b1001: en = ek + 3;
                4'b1010: en = ek + 2;
                4'b1110: begin em = ek - 1; en = ek + 5; end
                4'b1111: begin em = ek - 1; en = ek + 3; end
                default: en = ek + 1;
            endcase
        end else begin                                // R6 / R7
            case (w)
                4'b1000: en = ek + 3;
                4'b1001, 4'b1010: en = ek + 2;
                4'b1011, 4'b1100: en = ek + 1;
                default: begin en = ek + 1; ee = 1; end
            endcase
        end
    endtask

    task automatic apply(input logic [W-1:0] r, input string tag);
        int ek, em, en;
        bit ed, ez, ee;
        @(negedge clk);
        resid = r;
        @(negedge clk);                               // R9: one edge later
        model(r, ek, em, en, ed, ez, ee);
        checks++;
        if (int'(k_idx) != ek || int'(m_idx) != em || int'(n_idx) != en ||
            dir_neg != ed || zero_o != ez || err_o != ee) begin
            errors++;
            $display("FAIL %s resid=%h actual k=%0d m=%0d n=%0d d=%0b z=%0b e=%0b expected k=%0d m=%0d n=%0d d=%0b z=%0b e=%0b",
                     tag, r, k_idx, m_idx, n_idx, dir_neg, zero_o, err_o,
                     ek, em, en, ed, ez, ee);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] rv;
        resid = 12'h5A5;
        #1;
        repeat (3) @(negedge clk);
        checks++;
        if ({k_idx, m_idx, n_idx, dir_neg, zero_o, err_o} != '0) begin
            errors++;
            $display("FAIL R9 reset actual %h expected 0",
                     {k_idx, m_idx, n_idx, dir_neg, zero_o, err_o});
        end
        rst_n = 1'b1;

        apply(12'h000, "R1 zero");
        apply(12'h400, "R6 k0 1000");
        apply(12'h480, "R6 k0 1001");
        apply(12'h580, "R6 k0 1011");
        apply(12'h200, "R6 k1 1000");
        apply(12'h7FF, "R7 k0 1111");
        apply(12'h340, "R7 k1 1101");
        apply(12'h800, "R2 sign only");
        apply(12'hFFF, "R8 all ones");
        apply(12'h001, "R4 lsb pad");
        apply(12'h003, "R4 two bits");
        apply(12'hFFC, "R3 negative deep");
        for (int w = 8; w < 16; w++) begin            // R5 all windows
            apply(12'(w << 3), "R5 k4");
            apply(~12'(w << 3), "R5 k4 neg");
        end
        void'($urandom(32'd4711));
        for (int t = 0; t < 400; t++) begin
            rv = W'($urandom);
            if (t % 3 == 0) rv = rv >> ($urandom % W);
            apply(rv, "R3 random");
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule